// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits between a pending-interrupt queue and the processor's control state. Each cycle it looks at the head of the queue and decides whether that interrupt may be taken. It takes the interrupt only when traps are enabled and the interrupt's level is not below the current priority level. Level 15 is the exception: it is taken whatever the priority level.

The queue head arrives on a valid/ready pair. When the block takes the head, ready is high for that cycle and the queue pops it. When the head is refused, ready stays low and the entry stays queued. The queue must keep its head stable until it sees valid and ready together.

One cycle after acceptance, the block drives a set of write strobes:
- the status update (traps off, supervisor on, old supervisor saved);
- the saved-PC write, made under the supervisor privilege that the same update grants;
- the trap base register, rewritten with the handler offset in its trap-type field;
- a one-cycle PC load to the rewritten trap base value.

Top module: `int_entry_seq`

## Requirements
- R1: While `psr_et` is 0, `pend_ready` is 0 and no entry strobe follows, whatever the pending level.
- R2: With `psr_et` at 1, a pending level below 15 is taken only if it is greater than or equal to `psr_pil`; below it, `pend_ready` stays 0.
- R3: A pending level of 15 with `psr_et` at 1 is taken for every value of `psr_pil`.
- R4: `pend_ready` is high exactly in the cycles in which the head is taken; each such cycle pops one entry.
- R5: In the cycle after acceptance, `stat_we` is 1, `stat_et` is 0, `stat_s` is 1 and `stat_ps` equals `psr_s` as it was in the accepting cycle.
- R6: In that same cycle, `spc_we` is 1 with `stat_s` at 1, and `spc_data` equals `cur_pc` from the accepting cycle.
- R7: In that same cycle, `tbr_we` is 1 and `tbr_data` holds bits 31:12 and 3:0 of the accepting cycle's `tbr_in`, with `pend_offset` placed in bits 11:4.
- R8: `pc_load` is high for exactly one cycle per acceptance, with `pc_new` equal to `tbr_data`.
- R9: No interrupt is taken in a cycle in which entry strobes are being driven.
- R10: After reset, all strobes (`pend_ready`, `stat_we`, `spc_we`, `tbr_we`, `pc_load`) are 0 until an acceptance occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_valid | input | 1 | Queue head is present |
| pend_ready | output | 1 | Head taken this cycle; the queue pops it |
| pend_level | input | 4 | Level of the queue head |
| pend_offset | input | 8 | Handler offset of the queue head |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| psr_et | input | 1 | Traps enabled |
| psr_s | input | 1 | Current supervisor bit |
| psr_pil | input | 4 | Current priority interrupt level |
| tbr_in | input | 32 | Current trap base register |
| stat_we | output | 1 | Status bits update strobe |
| stat_et | output | 1 | New traps-enable value |
| stat_s | output | 1 | New supervisor value |
| stat_ps | output | 1 | New previous-supervisor value |
| spc_we | output | 1 | Saved-PC register write strobe |
| spc_data | output | 32 | Value written to the saved-PC register |
| tbr_we | output | 1 | Trap base register write strobe |
| tbr_data | output | 32 | New trap base register value |
| pc_load | output | 1 | Redirect strobe |
| pc_new | output | 32 | Redirect target |

## Verification
The assertions assume that every input carries a known value from the first clock edge after reset. They also assume that the pending level and offset are meaningful whenever `pend_valid` is high. They do not assume that the surrounding status register actually applies the strobes: the priority and enable inputs may change freely from one cycle to the next. The stimulus drives every input on the falling edge, from before reset is released. It mixes directed masking cases with long stretches of free values, so the inputs are never left undriven and back-to-back pending requests meet the one-cycle entry window.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;
  typedef struct packed {
    logic et;
    logic s;
    logic ps;
  } stat_bits_t;

  function automatic stat_bits_t entry_status(input logic old_s);
    stat_bits_t r;
    r.et = 1'b0;
    r.s  = 1'b1;
    r.ps = old_s;
    return r;
  endfunction
endpackage

// File: rtl/int_accept_gate.sv
module int_accept_gate #(
  parameter int LVL_W = 4
) (
  input  logic             valid,
  input  logic             busy,
  input  logic             et,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] pil,
  output logic             take
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  logic lvl_ok;
  always_comb begin
    lvl_ok = (level == TOP_LVL) || (level >= pil);
    take   = valid && !busy && et && lvl_ok;
  end
endmodule

// File: rtl/int_tbr_compose.sv
module int_tbr_compose #(
  parameter int ADDR_W = 32,
  parameter int TT_LSB = 4,
  parameter int TT_W   = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [TT_W-1:0]   tt,
  output logic [ADDR_W-1:0] vec
);
  localparam int TT_MSB = TT_LSB + TT_W - 1;

  generate
    if (TT_LSB > 0) begin : g_low
      assign vec = {base[ADDR_W-1:TT_MSB+1], tt, base[TT_LSB-1:0]};
    end else begin : g_nolow
      assign vec = {base[ADDR_W-1:TT_MSB+1], tt};
    end
  endgenerate
endmodule

// File: rtl/int_entry_regs.sv
module int_entry_regs
  import int_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              s_in,
  input  logic [ADDR_W-1:0] vec_in,
  output logic              busy,
  output stat_bits_t        stat,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      stat  <= '0;
      pc_q  <= '0;
      vec_q <= '0;
    end else begin
      busy <= take;
      if (take) begin
        stat  <= entry_status(s_in);
        pc_q  <= pc_in;
        vec_q <= vec_in;
      end
    end
  end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import int_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 4,
  parameter int TT_LSB = 4,
  parameter int TT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid,
  output logic              pend_ready,
  input  logic [LVL_W-1:0]  pend_level,
  input  logic [TT_W-1:0]   pend_offset,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              psr_et,
  input  logic              psr_s,
  input  logic [LVL_W-1:0]  psr_pil,
  input  logic [ADDR_W-1:0] tbr_in,
  output logic              stat_we,
  output logic              stat_et,
  output logic              stat_s,
  output logic              stat_ps,
  output logic              spc_we,
  output logic [ADDR_W-1:0] spc_data,
  output logic              tbr_we,
  output logic [ADDR_W-1:0] tbr_data,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_new
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  logic              busy;
  logic              take;
  logic [ADDR_W-1:0] vec_d;
  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] pc_q;
  stat_bits_t        stat;

  int_accept_gate #(.LVL_W(LVL_W)) u_gate (
    .valid (pend_valid),
    .busy  (busy),
    .et    (psr_et),
    .level (pend_level),
    .pil   (psr_pil),
    .take  (take)
  );

  int_tbr_compose #(.ADDR_W(ADDR_W), .TT_LSB(TT_LSB), .TT_W(TT_W)) u_tbr (
    .base (tbr_in),
    .tt   (pend_offset),
    .vec  (vec_d)
  );

  int_entry_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .pc_in  (cur_pc),
    .s_in   (psr_s),
    .vec_in (vec_d),
    .busy   (busy),
    .stat   (stat),
    .pc_q   (pc_q),
    .vec_q  (vec_q)
  );

  assign pend_ready = take;
  assign stat_we    = busy;
  assign stat_et    = stat.et;
  assign stat_s     = stat.s;
  assign stat_ps    = stat.ps;
  assign spc_we     = busy;
  assign spc_data   = pc_q;
  assign tbr_we     = busy;
  assign tbr_data   = vec_q;
  assign pc_load    = busy;
  assign pc_new     = vec_q;

  assert_no_take_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ready |-> psr_et);
  assert_level_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_ready && pend_level != TOP_LVL) |-> (pend_level >= psr_pil));
  assert_pop_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ready |-> pend_valid);
  assert_status_after_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ready |=> (stat_we && !stat_et && stat_s && stat_ps == $past(psr_s)));
  assert_spc_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spc_we |-> (stat_we && stat_s));
  assert_spc_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ready |=> (spc_data == $past(cur_pc)));
  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_new == tbr_data && tbr_we));
  assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !pend_ready);
endmodule

// File: tb/int_entry_seq_test.sv
`timescale 1ns/1ps
module int_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pend_valid = 1'b0;
  logic        pend_ready;
  logic [3:0]  pend_level = '0;
  logic [7:0]  pend_offset = '0;
  logic [31:0] cur_pc = '0;
  logic        psr_et = 1'b0;
  logic        psr_s = 1'b0;
  logic [3:0]  psr_pil = '0;
  logic [31:0] tbr_in = '0;
  logic        stat_we, stat_et, stat_s, stat_ps, spc_we, tbr_we, pc_load;
  logic [31:0] spc_data, tbr_data, pc_new;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  bit          m_busy = 1'b0;
  bit          m_ps;
  logic [31:0] m_pc;
  logic [31:0] m_tbr;
  bit          m_take;

  always #2 clk = ~clk;

  int_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_ready(pend_ready),
    .pend_level(pend_level), .pend_offset(pend_offset), .cur_pc(cur_pc),
    .psr_et(psr_et), .psr_s(psr_s), .psr_pil(psr_pil), .tbr_in(tbr_in),
    .stat_we(stat_we), .stat_et(stat_et), .stat_s(stat_s), .stat_ps(stat_ps),
    .spc_we(spc_we), .spc_data(spc_data), .tbr_we(tbr_we), .tbr_data(tbr_data),
    .pc_load(pc_load), .pc_new(pc_new)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(pc_load == m_busy, "R8 pc_load", 32'(pc_load), 32'(m_busy));
    chk(stat_we == m_busy, "R5 stat_we", 32'(stat_we), 32'(m_busy));
    chk(spc_we == m_busy, "R6 spc_we", 32'(spc_we), 32'(m_busy));
    chk(tbr_we == m_busy, "R7 tbr_we", 32'(tbr_we), 32'(m_busy));
    if (m_busy) begin
      chk(stat_et == 1'b0 && stat_s == 1'b1, "R5 et/s", {30'd0, stat_et, stat_s}, 32'd1);
      chk(stat_ps == m_ps, "R5 ps", 32'(stat_ps), 32'(m_ps));
      chk(spc_data == m_pc, "R6 spc_data", spc_data, m_pc);
      chk(tbr_data == m_tbr, "R7 tbr_data", tbr_data, m_tbr);
      chk(pc_new == m_tbr, "R8 pc_new", pc_new, m_tbr);
    end
  endtask

  // one cycle: drive at falling edge, check ready, advance model at rising edge
  task automatic step(input bit v, input logic [3:0] lvl, input logic [7:0] off,
                      input logic [31:0] pc, input bit et, input bit s,
                      input logic [3:0] pil, input logic [31:0] tbr, input string tag);
    pend_valid = v; pend_level = lvl; pend_offset = off; cur_pc = pc;
    psr_et = et; psr_s = s; psr_pil = pil; tbr_in = tbr;
    #1;
    m_take = v && !m_busy && et && (lvl == 4'd15 || lvl >= pil);
    chk(pend_ready == m_take, tag, 32'(pend_ready), 32'(m_take));
    @(posedge clk);
    m_busy = m_take;
    if (m_take) begin
      m_ps  = s;
      m_pc  = pc;
      m_tbr = (tbr & 32'hFFFF_F00F) | (32'(off) << 4);
    end
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(pend_ready == 0 && stat_we == 0 && spc_we == 0 && tbr_we == 0 && pc_load == 0,
        "R10 reset strobes", {27'd0, pend_ready, stat_we, spc_we, tbr_we, pc_load}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();
    // R1: traps off blocks every level, including 15
    step(1, 4'd7, 8'h11, 32'h0000_1000, 0, 0, 4'd0, 32'hABCD_E000, "R1 et=0 lvl7");
    step(1, 4'd15, 8'h12, 32'h0000_1004, 0, 1, 4'd0, 32'hABCD_E000, "R1 et=0 lvl15");
    // R2: level below pil refused, equal accepted
    step(1, 4'd3, 8'h20, 32'h0000_2000, 1, 0, 4'd5, 32'h1234_5678, "R2 below pil");
    step(1, 4'd5, 8'h21, 32'h0000_2004, 1, 0, 4'd5, 32'h1234_5678, "R2 equal pil");
    step(0, 4'd0, 8'h00, 32'h0, 1, 1, 4'd0, 32'h0, "R4 idle");
    // R3: level 15 at top pil; level 14 at top pil refused
    step(1, 4'd14, 8'h30, 32'h0000_3000, 1, 1, 4'd15, 32'hFFFF_FFFF, "R2 lvl14 pil15");
    step(1, 4'd15, 8'hA5, 32'h0000_3004, 1, 1, 4'd15, 32'hFFFF_FFFF, "R3 lvl15 pil15");
    // R9: back-to-back valid heads, second blocked during entry
    step(1, 4'd9, 8'h01, 32'h0000_4000, 1, 0, 4'd2, 32'h8000_000F, "R4 first take");
    step(1, 4'd9, 8'h02, 32'h0000_4004, 1, 0, 4'd2, 32'h8000_000F, "R9 blocked busy");
    step(1, 4'd9, 8'h02, 32'h0000_4004, 1, 1, 4'd2, 32'h8000_000F, "R4 retake");
    step(0, 4'd9, 8'h02, 32'h0, 1, 1, 4'd2, 32'h0, "R4 no valid");
    // free stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], 4'(r[7:4]), 8'(r[15:8]), $urandom, r[2] | r[3], r[16],
           4'(r[23:20]), $urandom, "R2 R3 R4 mixed");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule